// File: doc/BRIEF.md
# Audio FIFO Error and Interrupt Status

This block sits beside a playback FIFO and a capture FIFO and keeps a byte of sticky status for them. It watches host writes into the playback FIFO, converter sample requests against it, converter sample deliveries into the capture FIFO and host reads out of it. When any of these hits a full or empty FIFO, it sets a flag for that case and applies the data policy for it. A host write or an incoming converter sample into a full FIFO is dropped. A converter request on an empty FIFO is recorded as a missed sample. A host read from an empty FIFO returns the last good byte again.

Three pending-interrupt flags capture one-cycle event pulses from the playback DMA counter, the capture DMA counter and the timer. The block drives a single interrupt line while any of them is set. Every flag stays set until software clears it by writing a one to its bit. The FIFO storage, the DMA counters and the timer live outside the block. The block only gates the push and pop strobes that reach them.

Top module: `audio_fifo_status`

## Requirements
- R1: After synchronous reset, `status` is 8'h00, `irq` is 0 and `host_rd_data` is 0. Bit 7 of `status` always reads 0.
- R2: In a cycle where `dac_req` is high and `pb_empty` is high, `dac_take` stays low and `status` bit 0 (playback underrun) is 1 from the next cycle. With `pb_empty` low, `dac_take` follows `dac_req`.
- R3: In a cycle where `host_pb_wr` is high and `pb_full` is high, `pb_push` stays low (the write is dropped) and `status` bit 1 (playback overrun) is 1 from the next cycle. Otherwise `pb_push` follows `host_pb_wr`.
- R4: In a cycle where `adc_rdy` is high and `cap_full` is high, `cap_push` stays low (the sample is discarded) and `status` bit 2 (capture overrun) is 1 from the next cycle. Otherwise `cap_push` follows `adc_rdy`.
- R5: In a cycle where `host_cap_rd` is high and `cap_empty` is high, `cap_pop` stays low, `status` bit 3 (capture underrun) is 1 from the next cycle, and `host_rd_data` keeps its previous value.
- R6: In a cycle where `host_cap_rd` is high and `cap_empty` is low, `cap_pop` is high and `host_rd_data` shows the `cap_rdata` of that cycle from the next cycle on.
- R7: A high on `pb_dma_evt`, `cap_dma_evt` or `tmr_evt` sets `status` bit 4, 5 or 6 respectively, visible from the next cycle.
- R8: Every flag in bits 6..0 is sticky. A cycle with `clr_wr` high clears exactly the flags whose `clr_mask` bit is 1, and zero mask bits leave their flags unchanged.
- R9: When a flag's set event and its clear coincide in the same cycle, the flag is 1 afterwards.
- R10: `irq` is 1 exactly when any of `status` bits 6..4 is 1, and changes on the same clock edge as `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_full | input | 1 | Playback FIFO is full |
| pb_empty | input | 1 | Playback FIFO is empty |
| host_pb_wr | input | 1 | Host write strobe into the playback FIFO |
| dac_req | input | 1 | Output converter asks for a sample |
| cap_full | input | 1 | Capture FIFO is full |
| cap_empty | input | 1 | Capture FIFO is empty |
| adc_rdy | input | 1 | Input converter delivers a sample |
| host_cap_rd | input | 1 | Host read strobe from the capture FIFO |
| cap_rdata | input | DATA_W | Head byte of the capture FIFO |
| pb_dma_evt | input | 1 | Playback DMA count interrupt event |
| cap_dma_evt | input | 1 | Capture DMA count interrupt event |
| tmr_evt | input | 1 | Timer interrupt event |
| clr_wr | input | 1 | Write strobe for the clear mask |
| clr_mask | input | 8 | Write-one-to-clear mask, bit order as `status` |
| pb_push | output | 1 | Gated write into the playback FIFO |
| dac_take | output | 1 | Gated pop of the playback FIFO for the converter |
| cap_push | output | 1 | Gated write into the capture FIFO |
| cap_pop | output | 1 | Gated pop of the capture FIFO for the host |
| host_rd_data | output | DATA_W | Byte returned to the host on a capture read |
| status | output | 8 | Sticky flags: 0 pb underrun, 1 pb overrun, 2 cap overrun, 3 cap underrun, 4 pb DMA, 5 cap DMA, 6 timer, 7 zero |
| irq | output | 1 | Any pending-interrupt flag is set |

## Verification
The assertions take the full and empty indications at face value and do not require them to be mutually exclusive. They also take strobes and events as level-per-cycle pulses with no handshake, so any combination in one cycle is legal. The stimulus draws every strobe, flag and event independently each cycle from a seeded generator. The clear strobe is weighted low so that flags accumulate before they are cleared. Directed cycles add a set and clear of the same flag together, a clear with an all-zero mask, and back-to-back empty reads after a good read.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int NFLAG = 7;
  localparam int STAT_W = 8;
  localparam int B_PB_UNDER = 0;
  localparam int B_PB_OVER = 1;
  localparam int B_CAP_OVER = 2;
  localparam int B_CAP_UNDER = 3;
  localparam int B_PB_DMA = 4;
  localparam int B_CAP_DMA = 5;
  localparam int B_TMR = 6;
  localparam int IRQ_LO = B_PB_DMA;
  localparam int IRQ_HI = B_TMR;
endpackage

// File: rtl/afs_gate.sv
module afs_gate (
  input  logic pb_full,
  input  logic pb_empty,
  input  logic host_pb_wr,
  input  logic dac_req,
  input  logic cap_full,
  input  logic cap_empty,
  input  logic adc_rdy,
  input  logic host_cap_rd,
  output logic pb_push,
  output logic dac_take,
  output logic cap_push,
  output logic cap_pop,
  output logic err_pb_under,
  output logic err_pb_over,
  output logic err_cap_over,
  output logic err_cap_under
);
  always_comb begin
    err_pb_under  = dac_req & pb_empty;
    err_pb_over   = host_pb_wr & pb_full;
    err_cap_over  = adc_rdy & cap_full;
    err_cap_under = host_cap_rd & cap_empty;
    dac_take      = dac_req & ~pb_empty;
    pb_push       = host_pb_wr & ~pb_full;
    cap_push      = adc_rdy & ~cap_full;
    cap_pop       = host_cap_rd & ~cap_empty;
  end
endmodule

// File: rtl/afs_flag_bank.sv
module afs_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] flags_d
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set event outranks a clear in the same cycle
    assign flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_vec[i]);
    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end
  end
endmodule

// File: rtl/afs_hold_reg.sv
module afs_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
  import afs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pb_full,
  input  logic              pb_empty,
  input  logic              host_pb_wr,
  input  logic              dac_req,
  input  logic              cap_full,
  input  logic              cap_empty,
  input  logic              adc_rdy,
  input  logic              host_cap_rd,
  input  logic [DATA_W-1:0] cap_rdata,
  input  logic              pb_dma_evt,
  input  logic              cap_dma_evt,
  input  logic              tmr_evt,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  output logic              pb_push,
  output logic              dac_take,
  output logic              cap_push,
  output logic              cap_pop,
  output logic [DATA_W-1:0] host_rd_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic e_pb_under, e_pb_over, e_cap_over, e_cap_under;
  logic [NFLAG-1:0] set_vec, clr_vec, flags_q, flags_d;

  afs_gate u_gate (
    .pb_full(pb_full), .pb_empty(pb_empty), .host_pb_wr(host_pb_wr),
    .dac_req(dac_req), .cap_full(cap_full), .cap_empty(cap_empty),
    .adc_rdy(adc_rdy), .host_cap_rd(host_cap_rd),
    .pb_push(pb_push), .dac_take(dac_take), .cap_push(cap_push),
    .cap_pop(cap_pop),
    .err_pb_under(e_pb_under), .err_pb_over(e_pb_over),
    .err_cap_over(e_cap_over), .err_cap_under(e_cap_under)
  );

  always_comb begin
    set_vec = '0;
    set_vec[B_PB_UNDER]  = e_pb_under;
    set_vec[B_PB_OVER]   = e_pb_over;
    set_vec[B_CAP_OVER]  = e_cap_over;
    set_vec[B_CAP_UNDER] = e_cap_under;
    set_vec[B_PB_DMA]    = pb_dma_evt;
    set_vec[B_CAP_DMA]   = cap_dma_evt;
    set_vec[B_TMR]       = tmr_evt;
    clr_vec = clr_wr ? clr_mask[NFLAG-1:0] : '0;
  end

  afs_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags_q(flags_q), .flags_d(flags_d)
  );

  afs_hold_reg #(.W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load(cap_pop), .din(cap_rdata),
    .dout(host_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |flags_d[IRQ_HI:IRQ_LO];
  end

  assign status = {{(STAT_W-NFLAG){1'b0}}, flags_q};
endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pb_empty,
  input logic              pb_full,
  input logic              host_pb_wr,
  input logic              dac_req,
  input logic              cap_full,
  input logic              cap_empty,
  input logic              adc_rdy,
  input logic              host_cap_rd,
  input logic              clr_wr,
  input logic [7:0]        clr_mask,
  input logic              pb_push,
  input logic              cap_push,
  input logic [DATA_W-1:0] host_rd_data,
  input logic [7:0]        status,
  input logic              irq
);
  a_r1_bit7_zero: assert property (@(posedge clk) disable iff (rst)
    status[7] == 1'b0);
  a_r2_pb_underrun: assert property (@(posedge clk) disable iff (rst)
    (dac_req && pb_empty) |=> status[0]);
  a_r3_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (host_pb_wr && pb_full) |-> !pb_push);
  a_r4_sample_dropped: assert property (@(posedge clk) disable iff (rst)
    (adc_rdy && cap_full) |-> !cap_push);
  a_r5_byte_held: assert property (@(posedge clk) disable iff (rst)
    (host_cap_rd && cap_empty) |=> $stable(host_rd_data));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[3] && !(clr_wr && clr_mask[3])) |=> status[3]);
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (|status[6:4]));
endmodule

bind audio_fifo_status afs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pb_empty(pb_empty), .pb_full(pb_full),
  .host_pb_wr(host_pb_wr), .dac_req(dac_req), .cap_full(cap_full),
  .cap_empty(cap_empty), .adc_rdy(adc_rdy), .host_cap_rd(host_cap_rd),
  .clr_wr(clr_wr), .clr_mask(clr_mask), .pb_push(pb_push),
  .cap_push(cap_push), .host_rd_data(host_rd_data), .status(status),
  .irq(irq)
);

// File: tb/audio_fifo_status_tb.sv
`timescale 1ns/1ps
module audio_fifo_status_tb_top;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic pb_full = 0, pb_empty = 0, host_pb_wr = 0, dac_req = 0;
  logic cap_full = 0, cap_empty = 0, adc_rdy = 0, host_cap_rd = 0;
  logic [W-1:0] cap_rdata = 0;
  logic pb_dma_evt = 0, cap_dma_evt = 0, tmr_evt = 0, clr_wr = 0;
  logic [7:0] clr_mask = 0;
  logic pb_push, dac_take, cap_push, cap_pop, irq;
  logic [W-1:0] host_rd_data;
  logic [7:0] status;

  int total = 0, bad = 0;
  logic [6:0] m_flags = 0;
  logic [W-1:0] m_hold = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_fifo_status #(.DATA_W(W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] next_flags(input logic [6:0] f);
    logic [6:0] s;
    s = {tmr_evt, cap_dma_evt, pb_dma_evt, host_cap_rd & cap_empty,
         adc_rdy & cap_full, host_pb_wr & pb_full, dac_req & pb_empty};
    return s | (f & ~(clr_wr ? clr_mask[6:0] : 7'h0));
  endfunction

  // called just after inputs are driven at negedge; checks gates, advances model
  task automatic step();
    #1;
    chk(dac_take == (dac_req & ~pb_empty), "R2", dac_take, dac_req & ~pb_empty);
    chk(pb_push == (host_pb_wr & ~pb_full), "R3", pb_push, host_pb_wr & ~pb_full);
    chk(cap_push == (adc_rdy & ~cap_full), "R4", cap_push, adc_rdy & ~cap_full);
    chk(cap_pop == (host_cap_rd & ~cap_empty), "R5/R6", cap_pop, host_cap_rd & ~cap_empty);
    m_flags = next_flags(m_flags);
    if (host_cap_rd && !cap_empty) m_hold = cap_rdata;
    @(negedge clk);
    chk(status == {1'b0, m_flags}, "R2-status R8 R9", status, {1'b0, m_flags});
    chk(irq == (|m_flags[6:4]), "R10", irq, |m_flags[6:4]);
    chk(host_rd_data == m_hold, "R5 R6", host_rd_data, m_hold);
  endtask

  task automatic idle();
    {pb_full, pb_empty, host_pb_wr, dac_req, cap_full, cap_empty, adc_rdy,
     host_cap_rd, pb_dma_evt, cap_dma_evt, tmr_evt, clr_wr} = '0;
    clr_mask = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h00, "R1", status, 0);
    chk(irq == 0, "R1", irq, 0);
    chk(host_rd_data == 0, "R1", host_rd_data, 0);

    // R6 good read then R5 two empty reads keep the byte
    idle(); host_cap_rd = 1; cap_rdata = 8'hA5; step();
    idle(); host_cap_rd = 1; cap_empty = 1; cap_rdata = 8'h3C; step();
    idle(); host_cap_rd = 1; cap_empty = 1; cap_rdata = 8'h77; step();
    chk(host_rd_data == 8'hA5, "R5", host_rd_data, 8'hA5);
    // R7 timer event, R10 irq
    idle(); tmr_evt = 1; step();
    chk(status[6] && irq, "R7", status, 8'h48);
    // R8 zero mask keeps flags
    idle(); clr_wr = 1; clr_mask = 8'h00; step();
    chk(status == 8'h48, "R8", status, 8'h48);
    // R9 set and clear coincide on bit 0
    idle(); dac_req = 1; pb_empty = 1; clr_wr = 1; clr_mask = 8'h01; step();
    chk(status[0] == 1, "R9", status[0], 1);
    // R8 clear all, R10 irq drops
    idle(); clr_wr = 1; clr_mask = 8'hFF; step();
    chk(status == 8'h00 && irq == 0, "R8 R10", status, 0);

    for (int i = 0; i < 3000; i++) begin
      pb_full = $urandom_range(0, 3) == 0;
      pb_empty = $urandom_range(0, 3) == 0;
      host_pb_wr = $urandom_range(0, 1);
      dac_req = $urandom_range(0, 1);
      cap_full = $urandom_range(0, 3) == 0;
      cap_empty = $urandom_range(0, 3) == 0;
      adc_rdy = $urandom_range(0, 1);
      host_cap_rd = $urandom_range(0, 1);
      cap_rdata = W'($urandom);
      pb_dma_evt = $urandom_range(0, 15) == 0;
      cap_dma_evt = $urandom_range(0, 15) == 0;
      tmr_evt = $urandom_range(0, 15) == 0;
      clr_wr = $urandom_range(0, 7) == 0;
      clr_mask = 8'($urandom);
      step();
    end
    idle(); step();
    // R1 bit 7 stays zero
    chk(status[7] == 0, "R1", status[7], 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule